// File: doc/BRIEF.md
# Backlight Dimming PWM Generator

This block drives the brightness input of an LED backlight driver with a pulse-width modulated signal. A high output level means the backlight is lit and a low level means it is dark. The caller supplies a requested brightness as an integer percentage, a one-bit rate select, and a backlight-on input. The output runs at one of two low frequencies, set by parameters that must lie between 40 Hz and 80 Hz. Every timing quantity is derived from a parameter that gives the system clock frequency. Each period is divided into 100 equal steps, so the duty resolution is one percent of the period.

When the backlight is switched on, the driver needs a settling time during which very low duties are not allowed. For a parameterised start window (500 ms by default) counted from the on input, every period uses at least a raised minimum duty (5 %). After the window ends, the minimum drops to 1 %. Requests above 100 saturate to full on. The block samples a new duty and rate only at the boundary between two periods, so no period is ever cut short or changed part way through. Turning the backlight off parks the output low and restarts the start window for the next switch-on.

Top module: `bl_dim_pwm`

## Requirements
- R1: While reset is high, and on the first cycles after reset with `bl_on` low, `dim_pwm` is low.
- R2: While `bl_on` is low, `dim_pwm` stays low and does not toggle. `dim_pwm` goes low at the first rising clock edge that samples `bl_on` low. After `bl_on` is first sampled high, `dim_pwm` goes high at the second rising edge.
- R3: The period is 100·S clock cycles. S = CLK_HZ/(HZ_SLOW·100) when `rate_sel` = 0, and S = CLK_HZ/(HZ_FAST·100) when `rate_sel` = 1. Both rates must lie within 40 to 80 Hz.
- R4: In each period, `dim_pwm` is high for D·S consecutive cycles at the start of the period, where D is the effective duty in percent. It is low for the rest of the period.
- R5: A `level_pct` value above 100 is treated as 100, so `dim_pwm` stays high without a break.
- R6: For any period that starts within START_MS milliseconds after `bl_on` rises, the effective duty is at least FLOOR_START (5). Lower requests are raised to 5.
- R7: After the start window, every request from FLOOR_RUN (1) to 100 is used as given. A request of 0 is raised to 1.
- R8: `level_pct` and `rate_sel` are sampled only when a period begins. A change during a period leaves that period's high time and length unchanged, and it takes effect in the next period.
- R9: Dropping `bl_on` clears the start window. The next switch-on applies the FLOOR_START minimum again for a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| bl_on | input | 1 | Backlight on request |
| rate_sel | input | 1 | Rate select: 0 = HZ_SLOW, 1 = HZ_FAST |
| level_pct | input | 7 | Requested duty, integer percent |
| dim_pwm | output | 1 | Registered PWM output, high = backlight on |

## Verification
The assertions check on every cycle that the output is low after any cycle with the on input low, and that the step and prescale counters stay inside their ranges. They also check that the latched duty and rate hold steady inside a period, that the latched duty stays between 1 and 100, and that the raised minimum applies whenever the start window is open. Only the bench scenarios can show end-to-end timing. These cover the exact high time and period for random duties at both rates, the switch from the 5 % minimum to the 1 % minimum once the window expires, mid-period request changes that take effect one period later, saturation above 100, and re-arming of the window after the backlight is switched off and on again.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int PCT_W = 7;
  localparam int STEPS = 100;
  localparam int HZ_MIN = 40;
  localparam int HZ_MAX = 80;

  typedef logic [PCT_W-1:0] pct_t;

  localparam pct_t PCT_FULL = pct_t'(STEPS);

  function automatic pct_t sat_pct(input pct_t r);
    return (r > PCT_FULL) ? PCT_FULL : r;
  endfunction
endpackage

// File: rtl/bl_start_timer.sv
module bl_start_timer #(
  parameter int WIN_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(WIN_CYC - 1)) done <= 1'b1;
    end
  end

  assert_win_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!done && cnt == '0));

  assert_win_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && en) |=> done);
endmodule

// File: rtl/bl_duty_clamp.sv
module bl_duty_clamp
  import bl_pwm_pkg::*;
#(
  parameter int FLOOR_START = 5,
  parameter int FLOOR_RUN   = 1
) (
  input  pct_t req,
  input  logic win_done,
  output pct_t eff
);
  pct_t sat;
  pct_t floor_v;

  always_comb begin
    sat     = sat_pct(req);
    floor_v = win_done ? pct_t'(FLOOR_RUN) : pct_t'(FLOOR_START);
    eff     = (sat < floor_v) ? floor_v : sat;
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
#(
  parameter int STEP_SLOW = 12,
  parameter int STEP_FAST = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rate_sel,
  input  pct_t duty_eff,
  output logic pwm_out
);
  localparam int STEP_MAX = (STEP_SLOW > STEP_FAST) ? STEP_SLOW : STEP_FAST;
  localparam int PRE_W    = $clog2(STEP_MAX + 1);

  logic             run;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  pct_t             step_cnt;
  pct_t             duty_q;
  logic             rate_q;
  logic             step_end;
  logic             period_end;

  always_comb begin
    pre_lim    = rate_q ? PRE_W'(STEP_FAST - 1) : PRE_W'(STEP_SLOW - 1);
    step_end   = (pre_cnt == pre_lim);
    period_end = step_end && (step_cnt == pct_t'(STEPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run      <= 1'b0;
      pre_cnt  <= '0;
      step_cnt <= '0;
      duty_q   <= '0;
      rate_q   <= 1'b0;
      pwm_out  <= 1'b0;
    end else begin
      pwm_out <= run && (step_cnt < duty_q);
      if (!run || period_end) begin
        run      <= 1'b1;
        pre_cnt  <= '0;
        step_cnt <= '0;
        duty_q   <= duty_eff;
        rate_q   <= rate_sel;
      end else if (step_end) begin
        pre_cnt  <= '0;
        step_cnt <= step_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assert_off_low_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (step_cnt < pct_t'(STEPS) && pre_cnt <= pre_lim));

  assert_duty_range_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (duty_q >= pct_t'(1) && duty_q <= PCT_FULL));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (en && run && !period_end) |=> ($stable(duty_q) && $stable(rate_q)));
endmodule

// File: rtl/bl_dim_pwm.sv
module bl_dim_pwm
  import bl_pwm_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int HZ_SLOW     = 50,
  parameter int HZ_FAST     = 60,
  parameter int START_MS    = 500,
  parameter int FLOOR_START = 5,
  parameter int FLOOR_RUN   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bl_on,
  input  logic       rate_sel,
  input  logic [6:0] level_pct,
  output logic       dim_pwm
);
  localparam int STEP_SLOW = CLK_HZ / (HZ_SLOW * STEPS);
  localparam int STEP_FAST = CLK_HZ / (HZ_FAST * STEPS);
  localparam int WIN_CYC   = (CLK_HZ / 1000) * START_MS;

  if (HZ_SLOW < HZ_MIN || HZ_SLOW > HZ_MAX || HZ_FAST < HZ_MIN || HZ_FAST > HZ_MAX)
  begin : g_rate_bad
    $error("PWM rate parameter outside the permitted band");
  end

  logic win_done;
  pct_t duty_eff;

  bl_start_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (bl_on),
    .done (win_done)
  );

  bl_duty_clamp #(.FLOOR_START(FLOOR_START), .FLOOR_RUN(FLOOR_RUN)) u_clamp (
    .req      (level_pct),
    .win_done (win_done),
    .eff      (duty_eff)
  );

  bl_pwm_core #(.STEP_SLOW(STEP_SLOW), .STEP_FAST(STEP_FAST)) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (bl_on),
    .rate_sel (rate_sel),
    .duty_eff (duty_eff),
    .pwm_out  (dim_pwm)
  );

  assert_start_floor_R6: assert property (@(posedge clk) disable iff (rst)
    !win_done |-> (duty_eff >= pct_t'(FLOOR_START)));

  assert_run_floor_R7: assert property (@(posedge clk) disable iff (rst)
    win_done |-> (duty_eff >= pct_t'(FLOOR_RUN)));
endmodule

// File: tb/bl_dim_pwm_test.sv
module bl_dim_pwm_test;
  localparam int CLK_HZ = 60_000;
  localparam int WIN    = (CLK_HZ / 1000) * 500;
  localparam int LIMIT  = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bl_on = 1'b0;
  logic rate_sel = 1'b0;
  logic [6:0] level_pct = 7'd50;
  logic dim_pwm;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bl_dim_pwm #(.CLK_HZ(CLK_HZ), .HZ_SLOW(50), .HZ_FAST(60), .START_MS(500),
               .FLOOR_START(5), .FLOOR_RUN(1)) uut (
    .clk(clk), .rst(rst), .bl_on(bl_on), .rate_sel(rate_sel),
    .level_pct(level_pct), .dim_pwm(dim_pwm));

  function automatic int step_of(input bit f);
    return f ? CLK_HZ / 6000 : CLK_HZ / 5000;
  endfunction

  function automatic int eff_duty(input int d, input int fl);
    int s;
    s = (d > 100) ? 100 : d;
    return (s < fl) ? fl : s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = dim_pwm;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (!prev && dim_pwm) return;
      prev = dim_pwm;
    end
  endtask

  task automatic measure(output int hi, output int per);
    logic prev;
    hi = 1; per = 1; prev = dim_pwm;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (dim_pwm && !prev) return;
      per++;
      if (dim_pwm) hi++;
      prev = dim_pwm;
    end
  endtask

  task automatic sample(input int d, input bit f, input int fl, input string req);
    int hi, per;
    level_pct = 7'(d); rate_sel = f;
    wait_rise();
    measure(hi, per);
    check(hi == eff_duty(d, fl) * step_of(f), req, hi, eff_duty(d, fl) * step_of(f));
    check(per == 100 * step_of(f), "R3", per, 100 * step_of(f));
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    int c0, hi, per, highs, lows, d, old_d;
    bit f, old_f;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check(dim_pwm == 1'b0, "R1", dim_pwm, 0);
    rst = 1'b0;
    highs = 0;
    repeat (3000) begin
      @(negedge clk);
      if (dim_pwm) highs++;
    end
    check(highs == 0, "R2", highs, 0);

    // switch on with a request under the start minimum (R6)
    level_pct = 7'd2; rate_sel = 1'b0;
    bl_on = 1'b1; c0 = cyc;
    wait_rise();
    check(cyc - c0 == 2, "R2", cyc - c0, 2);
    measure(hi, per);
    check(hi == 5 * step_of(0), "R6", hi, 5 * step_of(0));
    check(per == 100 * step_of(0), "R3", per, 100 * step_of(0));

    for (int i = 0; i < 8; i++) begin
      d = int'($urandom % 20); f = 1'($urandom);
      if (cyc - c0 < WIN - 2500) sample(d, f, 5, "R6");
    end

    while (cyc - c0 < WIN + 2500) wait_rise();

    sample(0, 1'b0, 1, "R7");
    sample(0, 1'b1, 1, "R7");
    sample(1, 1'b0, 1, "R7");
    sample(99, 1'b1, 1, "R4");
    for (int i = 0; i < 16; i++) begin
      d = int'($urandom % 100); f = 1'($urandom);
      sample(d, f, 1, "R4");
    end

    // mid-period change (R8)
    old_d = 30; old_f = 1'b0;
    sample(old_d, old_f, 1, "R4");
    level_pct = 7'd70; rate_sel = 1'b1;
    measure(hi, per);
    check(hi == old_d * step_of(old_f), "R8", hi, old_d * step_of(old_f));
    check(per == 100 * step_of(old_f), "R8", per, 100 * step_of(old_f));
    measure(hi, per);
    check(hi == 70 * step_of(1), "R8", hi, 70 * step_of(1));
    check(per == 100 * step_of(1), "R8", per, 100 * step_of(1));

    // switch off mid-high, then re-arm (R2, R9)
    bl_on = 1'b0;
    @(negedge clk);
    check(dim_pwm == 1'b0, "R2", dim_pwm, 0);
    highs = 0;
    repeat (100) begin
      @(negedge clk);
      if (dim_pwm) highs++;
    end
    check(highs == 0, "R2", highs, 0);
    level_pct = 7'd0; rate_sel = 1'b0; bl_on = 1'b1;
    wait_rise();
    measure(hi, per);
    check(hi == 5 * step_of(0), "R9", hi, 5 * step_of(0));
    sample(3, 1'b1, 5, "R9");

    // saturation (R5)
    level_pct = 7'd120;
    wait_rise();
    lows = 0;
    repeat (2500) begin
      @(negedge clk);
      if (!dim_pwm) lows++;
    end
    check(lows == 0, "R5", lows, 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule